// File: doc/BRIEF.md
# Split-Radix Twiddle Address Generator

This block sequences the butterflies of an N = 2^S point split-radix FFT that is computed on a single radix-2 butterfly unit with shared memory. It walks S passes of 2^(S-1) butterflies in ascending order. For each butterfly it reports what the butterfly unit must do with the twiddle leg: nothing, a swap of the real and imaginary parts (multiplication by j), or a full complex multiplication. For the full multiplication case it also produces the coefficient address and the read enable shared by the upper-leg and lower-leg coefficient banks.

Membership of each butterfly in an L block is tracked from pass to pass in a small flag memory with one bit per butterfly. The flag memory is filled with ones after `start`. Each flag is then read as its butterfly is issued, and its updated value is written back in the following cycle. The coefficient banks are enabled only for butterflies that leave the L block, so the multipliers and coefficient memories stay quiet for all other butterflies. A parameter selects one of two butterfly orderings. The two orderings differ in which counter bit selects the j swap and in how the coefficient address is formed.

Top module: `srfft_twiddle_agen`

## Requirements
- R1: A `start` pulse sampled while idle begins a job: 2^(S-1) flag initialisation cycles, then S passes of 2^(S-1) butterflies each, butterflies ascending within a pass and passes ascending. `bfly_valid_o` is high for S*2^(S-1) consecutive cycles, and the first of these cycles is the (2^(S-1)+2)th clock edge after the edge that sampled `start`.
- R2: All flags are one at the start of pass 0, so pass 0 never asks for a complex multiplication. With S=4, butterflies 0 to 3 of pass 0 report mode 0 and butterflies 4 to 7 report mode 1.
- R3: In the default ordering, in pass P < S-1, the swap select is bit S-2-P of the butterfly index.
- R4: Flag update from one pass to the next: a flag of 0 becomes 1, a flag of 1 with the swap select set becomes 0, and a flag of 1 with the swap select clear stays 1. A butterfly whose flag is 0 reports mode 2. With S=4, butterflies 4 to 7 of pass 1 report mode 2.
- R5: In the last pass (P = S-1), every butterfly reports mode 0 with the enable low.
- R6: Mode encoding on `tw_mode_o`: 0 = no twiddle, 1 = j swap (flag 1, swap select 1), 2 = complex multiply (flag 0). `tw_en_o` is high exactly when the mode is 2.
- R7: In the default ordering, when enabled, `tw_addr_o` is the butterfly index shifted left by P-1 and truncated to S-2 bits, which is the index bits S-2-P down to 0 followed by P-1 zeros. When not enabled, `tw_addr_o` is 0.
- R8: With `ALT_ORDER`=1, the swap select is index bit S-2 in every pass except the last, and the enabled address is index bits S-2 down to 1. Rules R4 to R7 otherwise apply unchanged.
- R9: `done_o` is high for exactly one cycle, the cycle after the last butterfly of the last pass is presented, and `bfly_valid_o` is low in that cycle.
- R10: A `start` pulse that arrives while a job is running is ignored. The job completes with its normal count and timing, and no second job follows.
- R11: A new `start` after completion re-initialises every flag, so a second job produces the same sequence as the first.
- R12: After reset, `bfly_valid_o`, `done_o`, `tw_en_o`, `tw_mode_o` and `tw_addr_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a job (honoured only when idle) |
| tw_mode_o | output | 2 | Twiddle action for the presented butterfly |
| tw_addr_o | output | S-2 | Coefficient address for both coefficient banks |
| tw_en_o | output | 1 | Coefficient bank read enable |
| bfly_valid_o | output | 1 | Outputs describe a butterfly this cycle |
| done_o | output | 1 | One-cycle pulse after the final butterfly |

## Verification
A 16-point job in the default ordering covers every flag transition. Pass 0 gives only swaps and no-ops. Pass 1 gives multiplies for the upper half. Pass 2 mixes all three modes with shifted addresses, and the last pass forces no-ops, so a wrong counter bit, a wrong shift or a wrong update rule each shows up in a different pass. The same transform in the alternative ordering separates the two swap-select and address rules. A start pulse injected mid-job and a back-to-back second job distinguish a design that ignores busy starts and re-initialises its flags from one that restarts or keeps stale flags.

// File: rtl/srtw_pkg.sv
// Shared types for the split-radix twiddle address generator.
// Assumes: nothing beyond IEEE 1800-2017.
package srtw_pkg;

    // Action the butterfly unit applies on the twiddle leg
    typedef enum logic [1:0] {
        TWM_NONE  = 2'd0,
        TWM_JSWAP = 2'd1,
        TWM_CMUL  = 2'd2
    } twm_e;

    // Sequencer phases
    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_INIT = 2'd1,
        SQ_RUN  = 2'd2
    } sq_state_e;

endpackage

// File: rtl/srtw_seq.sv
// Butterfly/pass sequencer.
// Fills the flag memory with ones for 2^(S-1) cycles after start, then
// issues every butterfly index of every pass in ascending order.
// Assumes: S >= 3; start is honoured only in the idle phase.
module srtw_seq
    import srtw_pkg::*;
#(
    parameter int S  = 10,
    parameter int BW = S - 1,
    parameter int PW = $clog2(S)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    output logic          init_we_o,
    output logic          issue_o,
    output logic          issue_last_o,
    output logic [BW-1:0] bfly_o,
    output logic [PW-1:0] pass_o
);

    localparam logic [BW-1:0] BMAX  = '1;
    localparam logic [PW-1:0] PLAST = PW'(S - 1);

    sq_state_e     st;
    logic [BW-1:0] bcnt;
    logic [PW-1:0] pcnt;

    // Phase and counter progression
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= SQ_IDLE;
            bcnt <= '0;
            pcnt <= '0;
        end else begin
            unique case (st)
                SQ_IDLE: begin
                    if (start_i) begin
                        st   <= SQ_INIT;
                        bcnt <= '0;
                        pcnt <= '0;
                    end
                end
                SQ_INIT: begin
                    bcnt <= bcnt + 1'b1;
                    if (bcnt == BMAX) begin
                        st <= SQ_RUN;
                    end
                end
                SQ_RUN: begin
                    bcnt <= bcnt + 1'b1;
                    if (bcnt == BMAX) begin
                        if (pcnt == PLAST) begin
                            st   <= SQ_IDLE;
                            pcnt <= '0;
                        end else begin
                            pcnt <= pcnt + 1'b1;
                        end
                    end
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end

    // Phase decode toward memory and decoder
    always_comb begin
        init_we_o    = (st == SQ_INIT);
        issue_o      = (st == SQ_RUN);
        issue_last_o = (st == SQ_RUN) && (bcnt == BMAX) && (pcnt == PLAST);
        bfly_o       = bcnt;
        pass_o       = pcnt;
    end

    // R1
    pass_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pcnt <= PLAST);

    // R1
    init_to_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SQ_INIT && bcnt == BMAX) |=> (st == SQ_RUN && bcnt == '0 && pcnt == '0));

endmodule

// File: rtl/srtw_flag_ram.sv
// One-bit-per-butterfly flag memory: synchronous write, registered read.
// Assumes: a write and a read never target the same entry in one cycle.
module srtw_flag_ram #(
    parameter int DEPTH = 512,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic          wdata_i,
    input  logic          re_i,
    input  logic [AW-1:0] raddr_i,
    output logic          rdata_o
);

    logic mem [DEPTH];

    // Storage write
    always_ff @(posedge clk) begin
        if (we_i) begin
            mem[waddr_i] <= wdata_i;
        end
    end

    // Registered read port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_o <= 1'b1;
        end else if (re_i) begin
            rdata_o <= mem[raddr_i];
        end
    end

    // R4
    rw_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && re_i) |-> (waddr_i != raddr_i));

endmodule

// File: rtl/srtw_decode.sv
// Butterfly decoder.
// Holds the stage register aligned with the flag read, derives the swap
// select, the effective flag, the mode and the coefficient address, and
// returns the updated flag for write-back. Outputs are registered.
// Assumes: flag_i is the flag of the butterfly issued one cycle earlier.
module srtw_decode
    import srtw_pkg::*;
#(
    parameter int S         = 10,
    parameter int ALT_ORDER = 0,
    parameter int BW        = S - 1,
    parameter int PW        = $clog2(S),
    parameter int AW        = S - 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          issue_i,
    input  logic          issue_last_i,
    input  logic [BW-1:0] bfly_i,
    input  logic [PW-1:0] pass_i,
    input  logic          flag_i,
    output logic          wb_en_o,
    output logic [BW-1:0] wb_addr_o,
    output logic          wb_data_o,
    output logic [1:0]    mode_o,
    output logic [AW-1:0] addr_o,
    output logic          en_o,
    output logic          valid_o,
    output logic          done_o
);

    localparam logic [PW-1:0] PLAST = PW'(S - 1);

    logic          s1_vld;
    logic          s1_last;
    logic [BW-1:0] s1_b;
    logic [PW-1:0] s1_p;

    logic          in_last_pass;
    logic          swap_sel;
    logic          lblk_eff;
    logic [AW-1:0] addr_raw;
    twm_e          mode_c;
    logic          last_q;

    // Stage register aligned with the flag read latency
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_vld  <= 1'b0;
            s1_last <= 1'b0;
            s1_b    <= '0;
            s1_p    <= '0;
        end else begin
            s1_vld  <= issue_i;
            s1_last <= issue_last_i;
            s1_b    <= bfly_i;
            s1_p    <= pass_i;
        end
    end

    assign in_last_pass = (s1_p == PLAST);

    // Ordering variant: swap select and address formation
    generate
        if (ALT_ORDER != 0) begin : g_alt
            // Swap select from the top index bit; address drops bit 0
            always_comb begin
                swap_sel = s1_b[BW-1] & ~in_last_pass;
                addr_raw = s1_b[BW-1:1];
            end
        end else begin : g_std
            int            jsh;
            int            ash;
            logic [BW-1:0] jvec;
            logic [BW-1:0] avec;
            // Swap select walks down one bit per pass; address shifts up
            always_comb begin
                jsh      = in_last_pass ? 0 : (BW - 1 - int'(s1_p));
                ash      = (s1_p == '0) ? 0 : (int'(s1_p) - 1);
                jvec     = s1_b >> jsh;
                avec     = s1_b << ash;
                swap_sel = jvec[0] & ~in_last_pass;
                addr_raw = avec[AW-1:0];
            end
        end
    endgenerate

    // Mode decision and flag update
    always_comb begin
        lblk_eff = flag_i | in_last_pass;
        if (!lblk_eff) begin
            mode_c = TWM_CMUL;
        end else if (swap_sel) begin
            mode_c = TWM_JSWAP;
        end else begin
            mode_c = TWM_NONE;
        end
        wb_en_o   = s1_vld;
        wb_addr_o = s1_b;
        wb_data_o = ~(lblk_eff & swap_sel);
    end

    // Registered outputs toward the butterfly unit and coefficient banks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_o  <= TWM_NONE;
            addr_o  <= '0;
            en_o    <= 1'b0;
            valid_o <= 1'b0;
            last_q  <= 1'b0;
            done_o  <= 1'b0;
        end else begin
            mode_o  <= s1_vld ? mode_c : TWM_NONE;
            addr_o  <= (s1_vld && !lblk_eff) ? addr_raw : '0;
            en_o    <= s1_vld & ~lblk_eff;
            valid_o <= s1_vld;
            last_q  <= s1_vld & s1_last;
            done_o  <= last_q;
        end
    end

    // R5
    last_pass_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_vld && in_last_pass) |=> (mode_o == TWM_NONE && !en_o));

    // R4
    cmul_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_vld && !flag_i) |-> wb_data_o);

endmodule

// File: rtl/srfft_twiddle_agen.sv
// Split-radix twiddle address generator (top).
// Connects the sequencer, the flag memory and the decoder; the write port
// of the flag memory is shared between initialisation and write-back.
// Assumes: S >= 3; ALT_ORDER selects the alternative butterfly ordering.
module srfft_twiddle_agen
    import srtw_pkg::*;
#(
    parameter int S         = 10,
    parameter int ALT_ORDER = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    output logic [1:0]   tw_mode_o,
    output logic [S-3:0] tw_addr_o,
    output logic         tw_en_o,
    output logic         bfly_valid_o,
    output logic         done_o
);

    localparam int BW    = S - 1;
    localparam int PW    = $clog2(S);
    localparam int AW    = S - 2;
    localparam int DEPTH = 1 << BW;

    logic          init_we;
    logic          issue;
    logic          issue_last;
    logic [BW-1:0] bfly;
    logic [PW-1:0] pass;
    logic          flag_rd;
    logic          wb_en;
    logic [BW-1:0] wb_addr;
    logic          wb_data;
    logic          ram_we;
    logic [BW-1:0] ram_waddr;
    logic          ram_wdata;

    srtw_seq #(.S(S), .BW(BW), .PW(PW)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .init_we_o    (init_we),
        .issue_o      (issue),
        .issue_last_o (issue_last),
        .bfly_o       (bfly),
        .pass_o       (pass)
    );

    // Flag write port: initialisation has priority over write-back
    always_comb begin
        ram_we    = init_we | wb_en;
        ram_waddr = init_we ? bfly : wb_addr;
        ram_wdata = init_we ? 1'b1 : wb_data;
    end

    srtw_flag_ram #(.DEPTH(DEPTH), .AW(BW)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (ram_we),
        .waddr_i (ram_waddr),
        .wdata_i (ram_wdata),
        .re_i    (issue),
        .raddr_i (bfly),
        .rdata_o (flag_rd)
    );

    srtw_decode #(.S(S), .ALT_ORDER(ALT_ORDER), .BW(BW), .PW(PW), .AW(AW)) u_dec (
        .clk          (clk),
        .rst_n        (rst_n),
        .issue_i      (issue),
        .issue_last_i (issue_last),
        .bfly_i       (bfly),
        .pass_i       (pass),
        .flag_i       (flag_rd),
        .wb_en_o      (wb_en),
        .wb_addr_o    (wb_addr),
        .wb_data_o    (wb_data),
        .mode_o       (tw_mode_o),
        .addr_o       (tw_addr_o),
        .en_o         (tw_en_o),
        .valid_o      (bfly_valid_o),
        .done_o       (done_o)
    );

    // R11
    port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(init_we && wb_en));

    // R6
    en_cmul_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tw_en_o |-> (tw_mode_o == TWM_CMUL));

    // R7
    addr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tw_en_o |-> (tw_addr_o == '0));

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R9
    done_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(bfly_valid_o) && !bfly_valid_o));

endmodule

// File: tb/srfft_twiddle_agen_tb.sv
// Directed bench: one default-order and one alternative-order instance, S=4.
module srfft_twiddle_agen_tb;

    localparam int S  = 4;
    localparam int M  = 1 << (S - 1);
    localparam int AW = S - 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_s = 1'b0;
    logic start_a = 1'b0;

    logic [1:0]    s_mode, a_mode;
    logic [AW-1:0] s_addr, a_addr;
    logic          s_en, a_en, s_vld, a_vld, s_done, a_done;

    int checks = 0;
    int errs   = 0;
    int cyc    = 0;
    bit fin    = 1'b0;
    int seen [S][M];

    always #2 clk = ~clk;

    srfft_twiddle_agen #(.S(S), .ALT_ORDER(0)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_s),
        .tw_mode_o(s_mode), .tw_addr_o(s_addr), .tw_en_o(s_en),
        .bfly_valid_o(s_vld), .done_o(s_done));

    srfft_twiddle_agen #(.S(S), .ALT_ORDER(1)) u_dut_alt (
        .clk(clk), .rst_n(rst_n), .start_i(start_a),
        .tw_mode_o(a_mode), .tw_addr_o(a_addr), .tw_en_o(a_en),
        .bfly_valid_o(a_vld), .done_o(a_done));

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Watchdog: a hung run counts as a failed check
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !fin) begin
            fin = 1'b1;
            checks++;
            errs++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 20000);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    // R12: outputs idle after reset
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(s_vld == 0 && a_vld == 0, "R12", "valid after reset", s_vld, 0);
        chk(s_done == 0 && a_done == 0, "R12", "done after reset", s_done, 0);
        chk(s_en == 0 && a_en == 0, "R12", "enable after reset", s_en, 0);
        chk(s_mode == 0 && a_mode == 0, "R12", "mode after reset", s_mode, 0);
        chk(s_addr == 0 && a_addr == 0, "R12", "addr after reset", s_addr, 0);
    endtask

    // Full job against the requirement model; inject >= 0 pulses start mid-job
    task automatic run_check(input bit alt, input int inject);
        bit f [M];
        int k;
        for (int i = 0; i < M; i++) f[i] = 1'b1;
        @(negedge clk);
        if (alt) start_a = 1'b1; else start_s = 1'b1;
        @(negedge clk);
        start_a = 1'b0;
        start_s = 1'b0;
        k = 0;
        while (!(alt ? a_vld : s_vld) && k < 100) begin
            @(negedge clk);
            k++;
        end
        chk(k == M + 2, "R1", "first valid latency", k, M + 2);
        for (int p = 0; p < S; p++) begin
            for (int b = 0; b < M; b++) begin
                bit  last, fe, jb;
                int  em, ea, am, aa, ae, av;
                string tag;
                if (p * M + b > 0) begin
                    @(negedge clk);
                    start_s = 1'b0;
                    start_a = 1'b0;
                end
                if (p * M + b == inject) begin
                    if (alt) start_a = 1'b1; else start_s = 1'b1;
                end
                last = (p == S - 1);
                fe   = last || f[b];
                if (last) jb = 1'b0;
                else if (alt) jb = ((b >> (S - 2)) & 1) != 0;
                else jb = ((b >> (S - 2 - p)) & 1) != 0;
                em = fe ? (jb ? 1 : 0) : 2;
                if (fe) ea = 0;
                else if (alt) ea = b >> 1;
                else ea = (b << (p - 1)) & ((1 << AW) - 1);
                f[b] = !(fe && jb);
                av = alt ? a_vld : s_vld;
                am = alt ? a_mode : s_mode;
                aa = alt ? a_addr : s_addr;
                ae = alt ? a_en : s_en;
                if (last) tag = "R5";
                else if (p == 0) tag = "R2";
                else if (!fe) tag = "R4";
                else tag = alt ? "R8" : "R3";
                if (!alt) seen[p][b] = am;
                chk(av == 1, "R1", $sformatf("valid p%0d b%0d", p, b), av, 1);
                chk(am == em, tag, $sformatf("mode p%0d b%0d", p, b), am, em);
                chk(ae == (em == 2 ? 1 : 0), "R6", $sformatf("enable p%0d b%0d", p, b),
                    ae, (em == 2 ? 1 : 0));
                chk(aa == ea, alt ? "R8" : "R7", $sformatf("addr p%0d b%0d", p, b), aa, ea);
            end
        end
        @(negedge clk);
        start_s = 1'b0;
        start_a = 1'b0;
        chk((alt ? a_done : s_done) == 1, "R9", "done pulse", alt ? a_done : s_done, 1);
        chk((alt ? a_vld : s_vld) == 0, "R9", "valid low with done", alt ? a_vld : s_vld, 0);
        @(negedge clk);
        chk((alt ? a_done : s_done) == 0, "R9", "done one cycle", alt ? a_done : s_done, 0);
    endtask

    // R2 R4: explicit 16-point values from the default-order job
    task automatic t_std_job();
        run_check(1'b0, -1);
        for (int b = 0; b < 4; b++)
            chk(seen[0][b] == 0, "R2", $sformatf("pass0 b%0d no-op", b), seen[0][b], 0);
        for (int b = 4; b < 8; b++)
            chk(seen[0][b] == 1, "R2", $sformatf("pass0 b%0d swap", b), seen[0][b], 1);
        for (int b = 4; b < 8; b++)
            chk(seen[1][b] == 2, "R4", $sformatf("pass1 b%0d multiply", b), seen[1][b], 2);
    endtask

    // R8: alternative ordering
    task automatic t_alt_job();
        run_check(1'b1, -1);
    endtask

    // R10: start during a job is ignored
    task automatic t_busy_start();
        int extra;
        run_check(1'b0, 13);
        extra = 0;
        for (int i = 0; i < M + 6; i++) begin
            @(negedge clk);
            if (s_vld) extra++;
        end
        chk(extra == 0, "R10", "no second job after busy start", extra, 0);
    endtask

    // R11: back-to-back job reproduces the first
    task automatic t_restart();
        run_check(1'b0, -1);
        run_check(1'b0, -1);
    endtask

    initial begin
        t_reset();
        t_std_job();
        t_alt_job();
        t_busy_start();
        t_restart();
        if (!fin) begin
            fin = 1'b1;
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

endmodule